// File: doc/BRIEF.md
# Incremental-Rotation Hough Angle Sweeper

The block takes a stream of edge points (x, y) and, for every accepted point, produces the line distance r = x·cos(t) + y·sin(t) for every whole degree t from −90° to +90°, which is 181 results per point. No trigonometric table is used. At the start of a sweep the point is mapped to the −90° position: the first component becomes −y and the second becomes x. After that each step turns the two-component vector by a fixed 1°. One step costs four multiplications by the constants cos(1°) and sin(1°), which are signed fixed-point values with 16 fractional bits. The first component of the vector is the r of the current angle.

The rotator is pipelined and its pipeline is treated as a ring of `SLOTS` positions (C-slow operation). Up to `SLOTS` independent points sweep at once, and each of them advances one degree every `SLOTS` cycles. A new point may enter only the ring position that is about to arrive at the loading point, and only once that position has finished its previous sweep. Each result leaves with its angle index and the tag of its point, so a downstream vote accumulator can sort the interleaved results. The running state carries `GUARD` fractional bits more than the output, which keeps the rounding error that builds up over the 180 steps below one output LSB.

Top module: `hough_sweep`

## Requirements
- R1: Each accepted point produces exactly 181 outputs. Their angle indices run 0, 1, …, 180 in ascending order, and index k stands for t = (k − 90) degrees.
- R2: The output `out_r` at angle index k is within 1 LSB of x·cos(t) + y·sin(t) rounded to the nearest integer, with t = (k − 90)°. This holds across the whole signed input range, including the corners (−2^(IN_W−1), −2^(IN_W−1)) and (2^(IN_W−1)−1, 2^(IN_W−1)−1).
- R3: The output at angle index 0 equals −y exactly.
- R4: The index-0 output of a point, carrying that point's tag, is present in the cycle right after the clock edge that accepts the point. Each further output of the same point follows exactly `SLOTS` cycles after the previous one.
- R5: A point is taken only on a clock edge where both `in_valid` and `in_ready` are high. Every index-0 output comes from such an acceptance. While `in_ready` is low, a held point produces no output.
- R6: `in_ready` is high only when the ring position about to reach the loading point is idle. After `SLOTS` points are accepted on consecutive edges, `in_ready` is low until the first of them has finished its sweep.
- R7: During reset and in the cycle after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An edge point is offered |
| in_ready | output | 1 | The loading position is free; the point is taken at the edge when in_valid is also high |
| in_x | input | IN_W | Point x coordinate, two's complement |
| in_y | input | IN_W | Point y coordinate, two's complement |
| in_tag | input | TAG_W | Identifier carried along with every result of the point |
| out_valid | output | 1 | A result is present this cycle |
| out_angle | output | 8 | Angle index 0..180, meaning t = index − 90 degrees |
| out_r | output | IN_W+2 | Rounded line distance, two's complement |
| out_tag | output | TAG_W | Tag of the point that the result belongs to |

## Verification
On every cycle the assertions check the handshake-to-output relations: an acceptance yields an index-0 result with the right tag and the value −y on the next cycle, no index-0 result appears without an acceptance, the angle index never leaves 0..180, r stays inside the bound set by the largest radius, and the reset state holds. Only the bench's scenarios can show the properties that span a whole sweep. These are the numerical accuracy against real-valued trigonometry at every angle, the exact spacing of `SLOTS` cycles between a point's results, the full count of 181 ordered results per tag while several points interleave, and `in_ready` dropping once the ring is full. The bench sweeps a grid of points that includes the extreme coordinates.

// File: rtl/hough_sweep_pkg.sv
package hough_sweep_pkg;
    // rotation constants: 1 degree step, 16 fractional bits
    localparam int COEF_FRAC = 16;
    localparam int COEF_W    = 18;
    localparam logic signed [COEF_W-1:0] COS_STEP = 18'sd65526;
    localparam logic signed [COEF_W-1:0] SIN_STEP = 18'sd1144;
    // sweep length: -90..+90 degrees inclusive
    localparam int ANGLE_COUNT = 181;
    localparam int ANGLE_W     = $clog2(ANGLE_COUNT);
    localparam logic [ANGLE_W-1:0] ANGLE_LAST = ANGLE_W'(ANGLE_COUNT - 1);
endpackage

// File: rtl/hs_mul4.sv
// Four constant products of one rotation step.
module hs_mul4
    import hough_sweep_pkg::*;
#(
    parameter int SW = 20,
    parameter int PW = SW + COEF_W
) (
    input  logic signed [SW-1:0] r_i,
    input  logic signed [SW-1:0] s_i,
    output logic signed [PW-1:0] rc_o,
    output logic signed [PW-1:0] ss_o,
    output logic signed [PW-1:0] sc_o,
    output logic signed [PW-1:0] rs_o
);
    logic signed [PW-1:0] r_ext, s_ext, c_ext, n_ext;

    always_comb begin
        r_ext = PW'(r_i);
        s_ext = PW'(s_i);
        c_ext = PW'(COS_STEP);
        n_ext = PW'(SIN_STEP);
        rc_o  = r_ext * c_ext;
        ss_o  = s_ext * n_ext;
        sc_o  = s_ext * c_ext;
        rs_o  = r_ext * n_ext;
    end
endmodule

// File: rtl/hs_sum_round.sv
// Combines the products into the next vector, rounding off the coefficient fraction.
module hs_sum_round
    import hough_sweep_pkg::*;
#(
    parameter int SW = 20,
    parameter int PW = SW + COEF_W
) (
    input  logic signed [PW-1:0] rc_i,
    input  logic signed [PW-1:0] ss_i,
    input  logic signed [PW-1:0] sc_i,
    input  logic signed [PW-1:0] rs_i,
    output logic signed [SW-1:0] r_o,
    output logic signed [SW-1:0] s_o
);
    localparam logic signed [PW-1:0] HALF =
        {{(PW-COEF_FRAC){1'b0}}, 1'b1, {(COEF_FRAC-1){1'b0}}};

    logic signed [PW-1:0] r_sum, s_sum, r_sh, s_sh;

    always_comb begin
        r_sum = rc_i + ss_i + HALF;
        s_sum = sc_i - rs_i + HALF;
        r_sh  = r_sum >>> COEF_FRAC;
        s_sh  = s_sum >>> COEF_FRAC;
        r_o   = r_sh[SW-1:0];
        s_o   = s_sh[SW-1:0];
    end
endmodule

// File: rtl/hs_out_scale.sv
// Drops the guard bits with round-half-up.
module hs_out_scale #(
    parameter int SW    = 20,
    parameter int GUARD = 10,
    parameter int OUT_W = 10
) (
    input  logic signed [SW-1:0]    v_i,
    output logic signed [OUT_W-1:0] o_o
);
    localparam logic signed [SW-1:0] OHALF =
        {{(SW-GUARD){1'b0}}, 1'b1, {(GUARD-1){1'b0}}};

    logic signed [SW-1:0] v_sum, v_sh;

    always_comb begin
        v_sum = v_i + OHALF;
        v_sh  = v_sum >>> GUARD;
        o_o   = v_sh[OUT_W-1:0];
    end
endmodule

// File: rtl/hough_sweep.sv
module hough_sweep
    import hough_sweep_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int TAG_W = 8,
    parameter int GUARD = 10,
    parameter int SLOTS = 3,
    parameter int OUT_W = IN_W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_x,
    input  logic signed [IN_W-1:0]  in_y,
    input  logic [TAG_W-1:0]        in_tag,
    output logic                    out_valid,
    output logic [ANGLE_W-1:0]      out_angle,
    output logic signed [OUT_W-1:0] out_r,
    output logic [TAG_W-1:0]        out_tag
);
    localparam int SW = IN_W + 2 + GUARD;
    localparam int PW = SW + COEF_W;
    localparam int NS = SLOTS - 1;

    typedef struct packed {
        logic                 busy;
        logic signed [SW-1:0] r;
        logic signed [SW-1:0] s;
        logic [ANGLE_W-1:0]   ang;
        logic [TAG_W-1:0]     tag;
    } slot_t;

    typedef struct packed {
        logic                 busy;
        logic signed [PW-1:0] rc;
        logic signed [PW-1:0] ss;
        logic signed [PW-1:0] sc;
        logic signed [PW-1:0] rs;
        logic [ANGLE_W-1:0]   ang;
        logic [TAG_W-1:0]     tag;
    } prod_t;

    typedef struct packed {
        slot_t [NS-1:0] ring;
        prod_t          prod;
    } state_t;

    state_t state_d, state_q;

    logic signed [PW-1:0] rc_w, ss_w, sc_w, rs_w;
    logic signed [SW-1:0] r_nx, s_nx;
    slot_t                adv, arrive, load;
    logic signed [SW-1:0] x_ext, y_ext;

    hs_mul4 #(.SW(SW), .PW(PW)) u_mul (
        .r_i  (state_q.ring[0].r),
        .s_i  (state_q.ring[0].s),
        .rc_o (rc_w),
        .ss_o (ss_w),
        .sc_o (sc_w),
        .rs_o (rs_w)
    );

    hs_sum_round #(.SW(SW), .PW(PW)) u_sum (
        .rc_i (state_q.prod.rc),
        .ss_i (state_q.prod.ss),
        .sc_i (state_q.prod.sc),
        .rs_i (state_q.prod.rs),
        .r_o  (r_nx),
        .s_o  (s_nx)
    );

    hs_out_scale #(.SW(SW), .GUARD(GUARD), .OUT_W(OUT_W)) u_out (
        .v_i (state_q.ring[0].r),
        .o_o (out_r)
    );

    always_comb begin
        // token leaving the adder, one degree further on
        adv.busy = state_q.prod.busy;
        adv.r    = r_nx;
        adv.s    = s_nx;
        adv.ang  = state_q.prod.ang + 1'b1;
        adv.tag  = state_q.prod.tag;

        // token that will occupy the head next cycle
        if (NS == 1) arrive = adv;
        else         arrive = state_q.ring[NS-1];

        in_ready = !arrive.busy;

        // start of sweep: first component -y, second component x
        x_ext     = SW'(in_x);
        y_ext     = SW'(in_y);
        load.busy = 1'b1;
        load.r    = (-y_ext) <<< GUARD;
        load.s    = x_ext <<< GUARD;
        load.ang  = '0;
        load.tag  = in_tag;

        state_d = state_q;

        state_d.prod.busy = state_q.ring[0].busy && (state_q.ring[0].ang != ANGLE_LAST);
        state_d.prod.rc   = rc_w;
        state_d.prod.ss   = ss_w;
        state_d.prod.sc   = sc_w;
        state_d.prod.rs   = rs_w;
        state_d.prod.ang  = state_q.ring[0].ang;
        state_d.prod.tag  = state_q.ring[0].tag;

        for (int k = NS - 1; k >= 1; k--) begin
            if (k == 1) state_d.ring[k] = adv;
            else        state_d.ring[k] = state_q.ring[k-1];
        end

        if (in_valid && in_ready) state_d.ring[0] = load;
        else                      state_d.ring[0] = arrive;

        out_valid = state_q.ring[0].busy;
        out_angle = state_q.ring[0].ang;
        out_tag   = state_q.ring[0].tag;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/hough_sweep_chk.sv
module hough_sweep_chk
    import hough_sweep_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int TAG_W = 8,
    parameter int OUT_W = IN_W + 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic signed [IN_W-1:0]  in_x,
    input logic signed [IN_W-1:0]  in_y,
    input logic [TAG_W-1:0]        in_tag,
    input logic                    out_valid,
    input logic [ANGLE_W-1:0]      out_angle,
    input logic signed [OUT_W-1:0] out_r,
    input logic [TAG_W-1:0]        out_tag
);
    localparam logic signed [OUT_W-1:0] BOUND =
        OUT_W'((1 << (IN_W - 1)) + (1 << (IN_W - 2)));

    logic                    take;
    logic signed [OUT_W-1:0] neg_y;

    assign take  = in_valid && in_ready;
    assign neg_y = -(OUT_W'(in_y));

    // R4
    first_out_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (out_valid && out_angle == '0 && out_tag == $past(in_tag)));

    // R3
    start_value_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (out_r == $past(neg_y)));

    // R5
    origin_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_angle == '0) |-> $past(take));

    // R1
    angle_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_angle <= ANGLE_LAST));

    // R2
    r_bound_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_r <= BOUND && out_r >= -BOUND));

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));
endmodule

bind hough_sweep hough_sweep_chk #(.IN_W(IN_W), .TAG_W(TAG_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/hough_sweep_test.sv
module hough_sweep_test;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 8;
    localparam int TAG_W = 8;
    localparam int SLOTS = 3;
    localparam int OUT_W = IN_W + 2;
    localparam int NV    = 7;
    localparam int NPTS  = NV * NV;
    localparam real PI   = 3.14159265358979;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic signed [IN_W-1:0]  in_x = '0;
    logic signed [IN_W-1:0]  in_y = '0;
    logic [TAG_W-1:0]        in_tag = '0;
    logic                    out_valid;
    logic [7:0]              out_angle;
    logic signed [OUT_W-1:0] out_r;
    logic [TAG_W-1:0]        out_tag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int px [256];
    int py [256];
    int acc_edge [256];
    int acc_n [256];
    int got [256];
    int vals [NV] = '{-128, -77, -1, 0, 1, 50, 127};

    hough_sweep #(.IN_W(IN_W), .TAG_W(TAG_W), .SLOTS(SLOTS)) uut (
        .clk, .rst, .in_valid, .in_ready, .in_x, .in_y, .in_tag,
        .out_valid, .out_angle, .out_r, .out_tag
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic send(input int x, input int y, input int tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_x = IN_W'(x);
        in_y = IN_W'(y);
        in_tag = TAG_W'(tag);
        px[tag] = x;
        py[tag] = y;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        acc_edge[tag] = cyc + 1;
        acc_n[tag]++;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // result monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            int t, k;
            real e;
            int ei, d;
            t = int'(out_tag);
            k = int'(out_angle);
            chk(acc_n[t] > 0 && got[t] < 181 * acc_n[t], "R5 tag accepted", t, t);
            chk(k == got[t] % 181, "R1 angle order", k, got[t] % 181);
            chk(cyc == acc_edge[t] + k * SLOTS, "R4 timing", cyc, acc_edge[t] + k * SLOTS);
            e  = px[t] * $cos((k - 90) * PI / 180.0) + py[t] * $sin((k - 90) * PI / 180.0);
            ei = int'(e);
            d  = int'(out_r) - ei;
            chk(d <= 1 && d >= -1, "R2 accuracy", int'(out_r), ei);
            if (k == 0) chk(int'(out_r) == -py[t], "R3 start value", int'(out_r), -py[t]);
            got[t]++;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            acc_n[i] = 0;
            got[i] = 0;
            acc_edge[i] = 0;
            px[i] = 0;
            py[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R7 reset in_ready", int'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 after reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R7 after reset in_ready", int'(in_ready), 1);

        for (int i = 0; i < NPTS; i++) begin
            send(vals[i / NV], vals[i % NV], i);
            if (i == SLOTS - 1) begin
                @(negedge clk);
                #1;
                chk(in_ready == 1'b0, "R6 ring full", int'(in_ready), 0);
            end
        end

        repeat (181 * SLOTS + 10) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 idle after sweeps", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R6 free after sweeps", int'(in_ready), 1);
        for (int i = 0; i < NPTS; i++)
            chk(got[i] == 181 * acc_n[i], "R1 result count", got[i], 181 * acc_n[i]);
        chk(got[NPTS] == 0, "R5 unused tag silent", got[NPTS], 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule